// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table

This block holds the per-vector message table and the pending-bit array of one function. Both sit behind a 4 KB register window. Software programs each vector's target address, its payload and its mask through 32-bit reads and writes. Device logic raises per-vector interrupt request pulses. The block turns each accepted request into a message write, which is a 64-bit address and a 32-bit data word presented on a request/acknowledge port.

A vector counts as masked when its own mask bit is set or when the function-wide mask input is high. A request on a masked vector is remembered in the pending array, which software can only read. The message for it goes out automatically once the vector becomes unmasked. Device logic also keeps a use count for each vector through increment and decrement strobes. A vector whose count is zero is treated as unused: its requests are dropped, and when its count falls to zero any remembered request is discarded.

When several vectors are ready at once, the messages leave one at a time, lowest vector first. Each message waits for its acknowledge before the next one starts. The address and data of a message are captured when it is issued, so later table writes cannot alter it.

Top module: `msgvec_ctrl`

## Requirements
- R1: Each vector occupies 16 bytes at byte offset 16*v: word 0 is the low address half, word 1 the high address half, word 2 the payload, and word 3 the control word. Only bit 0 of the control word (the mask, 1 = masked) is stored; its other bits read as 0.
- R2: Register data appears on `reg_rdata` in the cycle after `reg_rd`. Address bits 1:0 are ignored, and the address is taken modulo 4096.
- R3: The word at byte offset 0x800 returns the pending bits, with vector v at bit v (byte v/8, bit v%8). Writes whose decoded vector index (offset/16) is NUM_VEC or more are discarded, including every write at or above 0x800. Unused locations read 0.
- R4: A vector is masked when its own mask bit is 1 or `func_mask` is 1.
- R5: A request on a masked, used vector sets its pending bit and sends no message.
- R6: A request on an unmasked, used vector, sampled at clock edge t, raises `msg_req` at edge t+1. The message carries that vector's stored address and payload.
- R7: When a vector with its pending bit set becomes unmasked, either by a control-word write or by `func_mask` falling, its pending bit clears and its message is sent.
- R8: A request on a vector whose use count is zero changes no pending bit and sends no message.
- R9: A decrement that brings a use count from 1 to 0 clears that vector's pending bit. A decrement at zero and an increment at the maximum leave the count unchanged.
- R10: Reset clears the whole table, the pending array and all use counts, sets every vector's mask bit, and drops `msg_req`.
- R11: Ready vectors are issued one message at a time in ascending index order. `msg_req` stays high until `msg_ack`, and falls on the edge that samples it.
- R12: `msg_addr` and `msg_data` hold their values while `msg_req` waits for `msg_ack`, even if the table is written during that time.
- R13: Several requests on one vector before its message is issued produce a single message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address; only the low 12 bits are decoded |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq_req | input | NUM_VEC | Per-vector interrupt request pulses |
| func_mask | input | 1 | Function-wide mask |
| use_inc | input | 1 | Increment the use count of use_idx |
| use_dec | input | 1 | Decrement the use count of use_idx |
| use_idx | input | 5 | Vector index for the use count strobes |
| msg_req | output | 1 | Message write request |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |
| msg_ack | input | 1 | Message accepted |

## Verification
A corrupted pending bit shows up on the next read of offset 0x800. It also shows up as a message that arrives, or fails to arrive, two cycles after the vector is unmasked. A wrong arbitration choice or a lost queued request appears at the message port as the wrong vector's address or a missing message, directly after the previous acknowledge. A wrong use count is only visible through its effect: a dropped or accepted request one cycle after the stimulus. The bench therefore follows every count change with a request and watches both the port and the pending word.

// File: rtl/msgvec_pkg.sv
`timescale 1ns/1ps
package msgvec_pkg;
  // decoded window is always 4 KB; pending words start at word offset 512
  localparam int WIN_AW  = 12;
  localparam int MAX_VEC = 32;

  typedef enum logic [1:0] {
    F_ADDR_LO = 2'd0,
    F_ADDR_HI = 2'd1,
    F_DATA    = 2'd2,
    F_CTRL    = 2'd3
  } field_e;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msg_t;
endpackage

// File: rtl/msgvec_table.sv
`timescale 1ns/1ps
module msgvec_table
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [WIN_AW-1:0]  win_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_VEC-1:0] pend,
  output logic [NUM_VEC-1:0] vmask,
  input  logic [IDX_W-1:0]   sel_idx,
  output msg_t               sel_msg
);
  localparam logic [7:0] NV = 8'(NUM_VEC);

  logic [9:0]       woff;
  logic [7:0]       vidx;
  logic [IDX_W-1:0] vi;
  field_e           fld;
  logic             in_pba;
  logic             in_tab;
  logic             unused_lsb;

  assign woff       = win_addr[WIN_AW-1:2];
  assign vidx       = woff[9:2];
  assign vi         = vidx[IDX_W-1:0];
  assign fld        = field_e'(woff[1:0]);
  assign in_pba     = woff[9];
  assign in_tab     = (vidx < NV);
  assign unused_lsb = ^win_addr[1:0];

  logic [31:0]        lo_q  [NUM_VEC];
  logic [31:0]        hi_q  [NUM_VEC];
  logic [31:0]        dat_q [NUM_VEC];
  logic [NUM_VEC-1:0] mask_q;
  logic [31:0]        rd_word;

  // read mux: pending word or table field, zero elsewhere
  always_comb begin
    rd_word = '0;
    if (in_pba) begin
      if (woff[8:0] == 9'd0) rd_word[NUM_VEC-1:0] = pend;
    end else if (in_tab) begin
      case (fld)
        F_ADDR_LO: rd_word    = lo_q[vi];
        F_ADDR_HI: rd_word    = hi_q[vi];
        F_DATA:    rd_word    = dat_q[vi];
        F_CTRL:    rd_word[0] = mask_q[vi];
        default:   rd_word    = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        lo_q[v]  <= '0;
        hi_q[v]  <= '0;
        dat_q[v] <= '0;
      end
      mask_q    <= '1;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && in_tab) begin
        case (fld)
          F_ADDR_LO: lo_q[vi]   <= reg_wdata;
          F_ADDR_HI: hi_q[vi]   <= reg_wdata;
          F_DATA:    dat_q[vi]  <= reg_wdata;
          F_CTRL:    mask_q[vi] <= reg_wdata[0];
          default:   ;
        endcase
      end
      if (reg_rd) reg_rdata <= rd_word;
    end
  end

  assign vmask        = mask_q;
  assign sel_msg.addr = {hi_q[sel_idx], lo_q[sel_idx]};
  assign sel_msg.data = dat_q[sel_idx];

  // R10: reset leaves every vector masked and read data cleared
  p_reset_masks_r10: assert property (@(posedge clk)
    rst |=> (mask_q == '1) && (reg_rdata == '0));

  // R3: writes decoding beyond the table never touch the masks
  p_high_write_discard_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !in_tab) |=> $stable(mask_q));
endmodule

// File: rtl/msgvec_usecnt.sv
`timescale 1ns/1ps
module msgvec_usecnt #(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               use_inc,
  input  logic               use_dec,
  input  logic [4:0]         use_idx,
  output logic [NUM_VEC-1:0] live,
  output logic [NUM_VEC-1:0] drop
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             up;
    logic             dn;

    assign hit = (use_idx == 5'(v));
    assign up  = use_inc & ~use_dec & hit;
    assign dn  = use_dec & ~use_inc & hit;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
      end else if (up && (cnt_q != '1)) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (dn && (cnt_q != '0)) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end

    assign live[v] = (cnt_q != '0);
    assign drop[v] = dn && (cnt_q == CNT_W'(1));

    // R9: no wrap below zero or above the maximum
    p_no_wrap_low_r9: assert property (@(posedge clk) disable iff (rst)
      (dn && (cnt_q == '0)) |=> (cnt_q == '0));
    p_no_wrap_high_r9: assert property (@(posedge clk) disable iff (rst)
      (up && (cnt_q == '1)) |=> (cnt_q == '1));
  end
endmodule

// File: rtl/msgvec_sched.sv
`timescale 1ns/1ps
module msgvec_sched
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic               func_mask,
  input  logic [NUM_VEC-1:0] vmask,
  input  logic [NUM_VEC-1:0] live,
  input  logic [NUM_VEC-1:0] drop,
  output logic [IDX_W-1:0]   sel_idx,
  input  msg_t               sel_msg,
  output logic [NUM_VEC-1:0] pend,
  input  logic               msg_ack,
  output logic               msg_req,
  output msg_t               msg
);
  logic [NUM_VEC-1:0] masked;
  logic [NUM_VEC-1:0] req_ok;
  logic [NUM_VEC-1:0] release_v;
  logic [NUM_VEC-1:0] issue_clr;
  logic [NUM_VEC-1:0] pend_q, pend_d;
  logic [NUM_VEC-1:0] fire_q, fire_d;
  logic               msg_req_q;
  msg_t               msg_q;
  logic               issue;

  assign masked    = vmask | {NUM_VEC{func_mask}};
  assign req_ok    = irq_req & live;
  assign release_v = pend_q & ~masked;

  // lowest queued vector wins
  always_comb begin
    sel_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (fire_q[i]) sel_idx = IDX_W'(i);
    end
  end

  assign issue = (|fire_q) & ~msg_req_q;

  always_comb begin
    issue_clr = '0;
    if (issue) issue_clr[sel_idx] = 1'b1;
    pend_d = ((pend_q & ~release_v) | (req_ok & masked)) & ~drop;
    fire_d = ((fire_q & ~issue_clr) | release_v | (req_ok & ~masked)) & ~drop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      fire_q    <= '0;
      msg_req_q <= 1'b0;
      msg_q     <= '0;
    end else begin
      pend_q <= pend_d;
      fire_q <= fire_d;
      if (issue) begin
        msg_req_q <= 1'b1;
        msg_q     <= sel_msg;
      end else if (msg_req_q && msg_ack) begin
        msg_req_q <= 1'b0;
      end
    end
  end

  assign pend    = pend_q;
  assign msg_req = msg_req_q;
  assign msg     = msg_q;

  // R12: an outstanding message is frozen until acknowledged
  p_hold_until_ack_r12: assert property (@(posedge clk) disable iff (rst)
    (msg_req && !msg_ack) |=> msg_req && $stable(msg.addr) && $stable(msg.data));

  // R11: acknowledge ends the message; the next one starts a cycle later
  p_release_on_ack_r11: assert property (@(posedge clk) disable iff (rst)
    (msg_req && msg_ack) |=> !msg_req);

  // R8: nothing is held for a vector whose use count is zero
  p_unused_clean_r8: assert property (@(posedge clk) disable iff (rst)
    ((pend_q | fire_q) & ~live) == '0);

  // R5: a pending bit only appears on a vector that was masked
  p_pend_only_masked_r5: assert property (@(posedge clk) disable iff (rst)
    (|(pend_q & ~$past(pend_q))) |-> ((pend_q & ~$past(pend_q) & ~$past(masked)) == '0));
endmodule

// File: rtl/msgvec_ctrl.sv
`timescale 1ns/1ps
module msgvec_ctrl
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic               func_mask,
  input  logic               use_inc,
  input  logic               use_dec,
  input  logic [4:0]         use_idx,
  output logic               msg_req,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data,
  input  logic               msg_ack
);
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] vmask;
  logic [NUM_VEC-1:0] live;
  logic [NUM_VEC-1:0] drop;
  logic [IDX_W-1:0]   sel_idx;
  msg_t               sel_msg;
  msg_t               msg;
  logic               unused_hi;

  // address is taken modulo the 4 KB window
  assign unused_hi = ^reg_addr[ADDR_W-1:WIN_AW];

  msgvec_table #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .win_addr  (reg_addr[WIN_AW-1:0]),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pend      (pend),
    .vmask     (vmask),
    .sel_idx   (sel_idx),
    .sel_msg   (sel_msg)
  );

  msgvec_usecnt #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) u_usecnt (
    .clk     (clk),
    .rst     (rst),
    .use_inc (use_inc),
    .use_dec (use_dec),
    .use_idx (use_idx),
    .live    (live),
    .drop    (drop)
  );

  msgvec_sched #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_sched (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq_req),
    .func_mask (func_mask),
    .vmask     (vmask),
    .live      (live),
    .drop      (drop),
    .sel_idx   (sel_idx),
    .sel_msg   (sel_msg),
    .pend      (pend),
    .msg_ack   (msg_ack),
    .msg_req   (msg_req),
    .msg       (msg)
  );

  assign msg_addr = msg.addr;
  assign msg_data = msg.data;
endmodule

// File: tb/sim_msgvec_ctrl.sv
`timescale 1ns/1ps
module sim_msgvec_ctrl;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [15:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NV-1:0] irq_req = '0;
  logic          func_mask = 1'b0;
  logic          use_inc = 1'b0;
  logic          use_dec = 1'b0;
  logic [4:0]    use_idx = '0;
  logic          msg_req;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;
  logic          msg_ack = 1'b0;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  msgvec_ctrl #(.NUM_VEC(NV), .CNT_W(4), .ADDR_W(16)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .func_mask(func_mask), .use_inc(use_inc), .use_dec(use_dec), .use_idx(use_idx),
    .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data), .msg_ack(msg_ack)
  );

  // {is_read, req, byte address, data or expected}
  localparam int NSTIM = 22;
  localparam logic [52:0] STIM [NSTIM] = '{
    {1'b0, 4'd1, 16'h0000, 32'h1000_0000},  // R1 v0 address low
    {1'b0, 4'd1, 16'h0004, 32'h0000_0001},
    {1'b0, 4'd1, 16'h0008, 32'h0000_00A0},
    {1'b0, 4'd1, 16'h0010, 32'h2000_0010},
    {1'b0, 4'd1, 16'h0018, 32'h0000_00B1},
    {1'b0, 4'd1, 16'h0020, 32'h3000_0020},
    {1'b0, 4'd1, 16'h0024, 32'h0000_0002},
    {1'b0, 4'd1, 16'h0028, 32'h0000_00C2},
    {1'b0, 4'd1, 16'h0030, 32'h4000_0030},
    {1'b0, 4'd1, 16'h0038, 32'h0000_00D3},
    {1'b0, 4'd3, 16'h0080, 32'hDEAD_BEEF},  // R3 vector 8 is out of range
    {1'b0, 4'd3, 16'h0800, 32'h0000_00FF},  // R3 pending word is read-only
    {1'b0, 4'd1, 16'h002C, 32'hFFFF_FFFE},  // R1 only bit 0 kept
    {1'b1, 4'd1, 16'h0000, 32'h1000_0000},
    {1'b1, 4'd2, 16'h0007, 32'h0000_0001},  // R2 low bits ignored
    {1'b1, 4'd2, 16'h1008, 32'h0000_00A0},  // R2 modulo 4 KB
    {1'b1, 4'd1, 16'h0024, 32'h0000_0002},
    {1'b1, 4'd1, 16'h002C, 32'h0000_0000},
    {1'b1, 4'd1, 16'h003C, 32'h0000_0001},
    {1'b1, 4'd3, 16'h0080, 32'h0000_0000},
    {1'b1, 4'd3, 16'h0800, 32'h0000_0000},
    {1'b1, 4'd1, 16'h0014, 32'h0000_0000}
  };

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(d == e, tag, 64'(d), 64'(e));
  endtask

  task automatic pulse(input int v);
    @(negedge clk);
    irq_req[v] = 1'b1;
    @(negedge clk);
    irq_req[v] = 1'b0;
  endtask

  task automatic use_op(input logic inc, input logic dec, input logic [4:0] idx);
    @(negedge clk);
    use_inc = inc; use_dec = dec; use_idx = idx;
    @(negedge clk);
    use_inc = 1'b0; use_dec = 1'b0;
  endtask

  task automatic no_msg(input int n, input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msg_req) seen = 1'b1;
    end
    chk(!seen, tag, 64'(seen), 64'd0);
  endtask

  task automatic wait_msg(input logic [63:0] ea, input logic [31:0] ed, input string tag);
    for (int i = 0; i < 20 && !msg_req; i++) @(negedge clk);
    chk(msg_req == 1'b1, tag, 64'(msg_req), 64'd1);
    chk(msg_addr == ea, tag, msg_addr, ea);
    chk(msg_data == ed, tag, 64'(msg_data), 64'(ed));
    msg_ack = 1'b1;
    @(negedge clk);
    msg_ack = 1'b0;
    chk(msg_req == 1'b0, tag, 64'(msg_req), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(msg_req == 1'b0, "R10 msg_req after reset", 64'(msg_req), 64'd0);
    rd_chk(16'h000C, 32'h1, "R10 v0 masked");
    rd_chk(16'h007C, 32'h1, "R10 v7 masked");
    rd_chk(16'h0800, 32'h0, "R10 pending clear");

    // table walk: R1 R2 R3
    for (int i = 0; i < NSTIM; i++) begin
      if (STIM[i][52]) rd_chk(STIM[i][47:32], STIM[i][31:0], $sformatf("R%0d table row %0d", STIM[i][51:48], i));
      else wr(STIM[i][47:32], STIM[i][31:0]);
    end

    for (int v = 0; v < 4; v++) use_op(1'b1, 1'b0, 5'(v));

    // R5 masked request is held pending
    pulse(0);
    no_msg(4, "R5 no message while masked");
    rd_chk(16'h0800, 32'h1, "R5 pending bit 0");
    // R8 unused vector dropped
    pulse(5);
    rd_chk(16'h0800, 32'h1, "R8 unused vector not pending");
    // R7 unmask by write releases the message
    wr(16'h000C, 32'h0);
    wait_msg(64'h0000_0001_1000_0000, 32'hA0, "R7 release on unmask write");
    rd_chk(16'h0800, 32'h0, "R7 pending cleared");

    // R6 direct delivery, exact latency
    pulse(0);
    chk(msg_req == 1'b0, "R6 not yet raised", 64'(msg_req), 64'd0);
    @(negedge clk);
    chk(msg_req == 1'b1, "R6 raised one edge later", 64'(msg_req), 64'd1);
    wait_msg(64'h0000_0001_1000_0000, 32'hA0, "R6 direct message");

    // R4 function mask holds an unmasked vector
    func_mask = 1'b1;
    pulse(0);
    no_msg(4, "R4 function mask suppresses");
    rd_chk(16'h0800, 32'h1, "R4 pending under function mask");
    @(negedge clk); func_mask = 1'b0;
    wait_msg(64'h0000_0001_1000_0000, 32'hA0, "R7 release on function unmask");

    // R11 ordering and R12 capture
    wr(16'h001C, 32'h0);
    func_mask = 1'b1;
    pulse(2);
    pulse(1);
    rd_chk(16'h0800, 32'h6, "R11 two pending");
    @(negedge clk); func_mask = 1'b0;
    for (int i = 0; i < 20 && !msg_req; i++) @(negedge clk);
    chk(msg_addr == 64'h0000_0000_2000_0010, "R11 lowest first", msg_addr, 64'h2000_0010);
    wr(16'h0018, 32'h55);
    chk(msg_req == 1'b1, "R11 waits for ack", 64'(msg_req), 64'd1);
    chk(msg_data == 32'hB1, "R12 data frozen", 64'(msg_data), 64'hB1);
    msg_ack = 1'b1;
    @(negedge clk);
    msg_ack = 1'b0;
    wait_msg(64'h0000_0002_3000_0020, 32'hC2, "R11 second vector");

    // R13 coalescing on v3 (masked since reset)
    pulse(3);
    pulse(3);
    rd_chk(16'h0800, 32'h8, "R13 pending bit 3");
    wr(16'h003C, 32'h0);
    wait_msg(64'h0000_0000_4000_0030, 32'hD3, "R13 single message");
    no_msg(6, "R13 no second message");

    // R9 decrement to zero clears pending
    func_mask = 1'b1;
    pulse(3);
    rd_chk(16'h0800, 32'h8, "R9 pending before decrement");
    use_op(1'b0, 1'b1, 5'd3);
    rd_chk(16'h0800, 32'h0, "R9 pending cleared by decrement");
    @(negedge clk); func_mask = 1'b0;
    no_msg(5, "R9 nothing released");
    use_op(1'b0, 1'b1, 5'd3);
    pulse(3);
    no_msg(5, "R9 count stayed at zero");

    // R10 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(msg_req == 1'b0, "R10 msg_req low", 64'(msg_req), 64'd0);
    rd_chk(16'h000C, 32'h1, "R10 mask set again");
    rd_chk(16'h0000, 32'h0, "R10 table cleared");
    rd_chk(16'h0800, 32'h0, "R10 pending cleared");
    wr(16'h001C, 32'h0);
    pulse(1);
    no_msg(5, "R10 use counts cleared");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule